// File: doc/BRIEF.md
# Linked-Channel Buffered PWM Timer

This block is a free-running up counter with a programmable modulus and two compare channels. Each channel drives its own output pin. The pin goes high when the counter wraps and goes low when the counter reaches the channel's compare value. In the default mode the two channels are independent, and a new compare value acts as soon as it is written.

A control bit joins the two channels into one buffered PWM output on the channel 0 pin. While they are joined, the two compare registers take turns as the active pulse width. The register written most recently becomes active, but only at the next counter wrap. Software can therefore load the idle register at any time in a period without glitching the pulse that is in progress. While joined, the channel 1 pin is released and carries a general-purpose input value instead. Wrap and compare events each set a sticky flag, and each flag has its own interrupt enable.

Top module: `lpwm_timer`

## Requirements
- R1: Write address map: 0 = modulus, 1 = channel 0 compare, 2 = channel 1 compare, 3 = control, 4 = flag clear. Control bits: bit 4 run, bit 0 link, bit 1 wrap interrupt enable, bit 2 channel 0 compare interrupt enable, bit 3 channel 1 compare interrupt enable. Flag and clear bits: bit 0 wrap, bit 1 channel 0 compare, bit 2 channel 1 compare. After reset, both pins are low, all flags are clear, the interrupt is low, and the counter stays idle until run is set.
- R2: While running, the counter steps from 0 to the modulus, returns to 0, and sets the wrap flag once every modulus+1 cycles.
- R3: For a compare value C, the channel pin is high while the counter holds 0..C-1. C = 0 keeps the pin low, and C above the modulus keeps it high for the whole period.
- R4: With link set, the channel 0 pin carries the buffered PWM, and the channel 0 compare register sets the width until the other register is written.
- R5: While linked, a write to the channel 1 compare register leaves the current period unchanged, and the new value sets the width from the next wrap onward.
- R6: While linked, the width chosen at each wrap comes from whichever compare register was written last in the period, so the later of two writes wins.
- R7: While linked, the channel 1 pin follows the gp_in input, and the channel 1 compare flag never sets, whatever its enable bit holds.
- R8: A flag sets on its event and stays set until a one is written to its bit at address 4. A compare flag sets when the counter steps onto the compare value. irq_o is high while any flag with its enable bit set is high.
- R9: Clearing link returns both channels to independent operation, with the channel 0 register active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| gp_in | input | 1 | Value driven on the channel 1 pin while linked |
| pwm0_o | output | 1 | Channel 0 / buffered PWM pin |
| pwm1_o | output | 1 | Channel 1 pin, or gp_in while linked |
| flag_o | output | 3 | Sticky event flags |
| irq_o | output | 1 | OR of the enabled flags |

## Verification
The hardest case to reach is a write that lands inside a period while the channels are linked. A test of that case has to know which register is active, which was written last, and where the counter stands when the write arrives. The bench first locks to a wrap by clearing the wrap flag and waiting for it to set again. It then counts cycles from that point and drives writes at chosen offsets inside a measured period. It places one or two writes, to either register, in one period and compares the high-cycle count of that period and of the next one.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
  localparam int NCH    = 2;
  localparam int CTRL_W = 5;
  localparam int FLAG_W = 3;

  typedef enum logic [2:0] {
    A_MOD  = 3'd0,
    A_CH0  = 3'd1,
    A_CH1  = 3'd2,
    A_CTRL = 3'd3,
    A_CLR  = 3'd4
  } addr_e;

  // control register bits
  localparam int C_LINK    = 0;
  localparam int C_OVF_IE  = 1;
  localparam int C_CMP0_IE = 2;
  localparam int C_CMP1_IE = 3;
  localparam int C_RUN     = 4;

  // flag bits
  localparam int F_OVF  = 0;
  localparam int F_CMP0 = 1;
  localparam int F_CMP1 = 2;
endpackage

// File: rtl/lpwm_rst_sync.sv
module lpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [2:0]                  wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic [CNT_W-1:0]            mod_q,
  output logic [NCH-1:0][CNT_W-1:0]   ch_q,
  output logic [CTRL_W-1:0]           ctrl_q,
  output logic [NCH-1:0]              wr_ch,
  output logic                        link_chg,
  output logic [FLAG_W-1:0]           clr_mask
);
  logic                      sel_mod;
  logic                      sel_ctrl;
  logic                      sel_clr;
  logic [CNT_W-1:0]          mod_d;
  logic [NCH-1:0][CNT_W-1:0] ch_d;
  logic [CTRL_W-1:0]         ctrl_d;

  // address decode
  always_comb begin
    sel_mod   = wr_en && (wr_addr == A_MOD);
    sel_ctrl  = wr_en && (wr_addr == A_CTRL);
    sel_clr   = wr_en && (wr_addr == A_CLR);
    wr_ch[0]  = wr_en && (wr_addr == A_CH0);
    wr_ch[1]  = wr_en && (wr_addr == A_CH1);
    link_chg  = sel_ctrl && (wr_data[C_LINK] != ctrl_q[C_LINK]);
    clr_mask  = sel_clr ? wr_data[FLAG_W-1:0] : '0;
  end

  // next state
  always_comb begin
    mod_d  = mod_q;
    ch_d   = ch_q;
    ctrl_d = ctrl_q;
    if (sel_mod)  mod_d  = wr_data;
    if (sel_ctrl) ctrl_d = wr_data[CTRL_W-1:0];
    for (int i = 0; i < NCH; i++) begin
      if (wr_ch[i]) ch_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '1;
      ch_q   <= '0;
      ctrl_q <= '0;
    end else begin
      mod_q  <= mod_d;
      ch_q   <= ch_d;
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/lpwm_counter.sv
module lpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] mod,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_inc = cnt_q + ONE;
    // wrap also when the modulus was lowered below the current count
    ovf_evt = run && (cnt_q >= mod);
    cnt_d   = cnt_q;
    if (ovf_evt)  cnt_d = '0;
    else if (run) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpwm_chan.sv
module lpwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ovf_evt,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] set_val,
  output logic             out_q,
  output logic             cmp_evt
);
  logic out_d;

  always_comb begin
    // compare event: counter steps onto the compare value inside a period
    cmp_evt = run && !ovf_evt && (cmp_val != '0) && (cnt_inc == cmp_val);
    out_d   = out_q;
    if (ovf_evt)      out_d = (set_val != '0);  // set at wrap, unless 0% duty
    else if (cmp_evt) out_d = 1'b0;             // clear at compare
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/lpwm_link.sv
module lpwm_link
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      link,
  input  logic                      link_chg,
  input  logic [NCH-1:0]            wr_ch,
  input  logic                      ovf_evt,
  input  logic [NCH-1:0][CNT_W-1:0] ch_q,
  output logic [CNT_W-1:0]          act_val,
  output logic [CNT_W-1:0]          nxt_val,
  output logic                      sel_q
);
  logic last_q;
  logic last_d;
  logic sel_d;

  always_comb begin
    // pointer to the register written most recently
    last_d = last_q;
    if (link_chg)      last_d = 1'b0;
    else if (wr_ch[1]) last_d = 1'b1;
    else if (wr_ch[0]) last_d = 1'b0;

    // active register changes only at a wrap while linked
    sel_d = sel_q;
    if (link_chg)                 sel_d = 1'b0;
    else if (link && ovf_evt)     sel_d = last_q;

    act_val = sel_q  ? ch_q[1] : ch_q[0];
    nxt_val = last_q ? ch_q[1] : ch_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      last_q <= last_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/lpwm_flags.sv
module lpwm_flags #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] evt,
  input  logic [FW-1:0] clr,
  input  logic [FW-1:0] en,
  output logic [FW-1:0] flags_q,
  output logic          irq
);
  logic [FW-1:0] flags_d;

  // an event in the same cycle as its clear keeps the flag set
  always_comb begin
    flags_d = (flags_q & ~clr) | evt;
    irq     = |(flags_q & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/lpwm_timer.sv
module lpwm_timer
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              gp_in,
  output logic              pwm0_o,
  output logic              pwm1_o,
  output logic [FLAG_W-1:0] flag_o,
  output logic              irq_o
);
  logic                      rst_s_n;
  logic [CNT_W-1:0]          mod_w;
  logic [NCH-1:0][CNT_W-1:0] ch_w;
  logic [CTRL_W-1:0]         ctrl_w;
  logic [NCH-1:0]            wr_ch_w;
  logic                      link_chg_w;
  logic [FLAG_W-1:0]         clr_w;
  logic [CNT_W-1:0]          cnt_w;
  logic [CNT_W-1:0]          cnt_inc_w;
  logic                      ovf_w;
  logic [CNT_W-1:0]          act_w;
  logic [CNT_W-1:0]          nxt_w;
  logic                      sel_w;
  logic [NCH-1:0][CNT_W-1:0] cmp_v;
  logic [NCH-1:0][CNT_W-1:0] set_v;
  logic [NCH-1:0]            out_v;
  logic [NCH-1:0]            hit_v;
  logic [FLAG_W-1:0]         evt_w;
  logic [FLAG_W-1:0]         en_w;
  logic                      link_w;
  logic                      run_w;

  lpwm_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  lpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mod_q    (mod_w),
    .ch_q     (ch_w),
    .ctrl_q   (ctrl_w),
    .wr_ch    (wr_ch_w),
    .link_chg (link_chg_w),
    .clr_mask (clr_w)
  );

  assign link_w = ctrl_w[C_LINK];
  assign run_w  = ctrl_w[C_RUN];

  lpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .run     (run_w),
    .mod     (mod_w),
    .cnt_q   (cnt_w),
    .cnt_inc (cnt_inc_w),
    .ovf_evt (ovf_w)
  );

  lpwm_link #(.CNT_W(CNT_W)) u_link (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .link     (link_w),
    .link_chg (link_chg_w),
    .wr_ch    (wr_ch_w),
    .ovf_evt  (ovf_w),
    .ch_q     (ch_w),
    .act_val  (act_w),
    .nxt_val  (nxt_w),
    .sel_q    (sel_w)
  );

  // channel 0 takes the alternating register pair when linked
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      if (g == 0) begin : g_buf
        assign cmp_v[g] = link_w ? act_w : ch_w[g];
        assign set_v[g] = link_w ? nxt_w : ch_w[g];
      end else begin : g_plain
        assign cmp_v[g] = ch_w[g];
        assign set_v[g] = ch_w[g];
      end

      lpwm_chan #(.CNT_W(CNT_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_s_n),
        .run     (run_w),
        .ovf_evt (ovf_w),
        .cnt_inc (cnt_inc_w),
        .cmp_val (cmp_v[g]),
        .set_val (set_v[g]),
        .out_q   (out_v[g]),
        .cmp_evt (hit_v[g])
      );
    end
  endgenerate

  always_comb begin
    evt_w         = '0;
    evt_w[F_OVF]  = ovf_w;
    evt_w[F_CMP0] = hit_v[0];
    evt_w[F_CMP1] = hit_v[1] && !link_w;
    en_w          = '0;
    en_w[F_OVF]   = ctrl_w[C_OVF_IE];
    en_w[F_CMP0]  = ctrl_w[C_CMP0_IE];
    en_w[F_CMP1]  = ctrl_w[C_CMP1_IE] && !link_w;
  end

  lpwm_flags #(.FW(FLAG_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .evt     (evt_w),
    .clr     (clr_w),
    .en      (en_w),
    .flags_q (flag_o),
    .irq     (irq_o)
  );

  assign pwm0_o = out_v[0];
  assign pwm1_o = link_w ? gp_in : out_v[1];
endmodule

// File: rtl/lpwm_checker.sv
module lpwm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             link,
  input logic             link_chg,
  input logic             ovf,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod,
  input logic [CNT_W-1:0] ch0,
  input logic             pwm0,
  input logic             pwm1,
  input logic             gp_in,
  input logic             sel,
  input logic             flag_ovf,
  input logic             flag_c1,
  input logic             clr_ovf
);
  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt >= mod) |=> (cnt == '0));

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt < mod) |=> (cnt == $past(cnt) + 1'b1));

  assert_rise_only_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !pwm0) |=> !pwm0);

  assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !link && ch0 == '0) |=> !pwm0);

  assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !link_chg) |=> $stable(sel));

  assert_gpio_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link |-> (pwm1 == gp_in));

  assert_cmp1_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link && !flag_c1) |=> !flag_c1);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovf && !clr_ovf) |=> flag_ovf);
endmodule

bind lpwm_timer lpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .run      (run_w),
  .link     (link_w),
  .link_chg (link_chg_w),
  .ovf      (ovf_w),
  .cnt      (cnt_w),
  .mod      (mod_w),
  .ch0      (ch_w[0]),
  .pwm0     (pwm0_o),
  .pwm1     (pwm1_o),
  .gp_in    (gp_in),
  .sel      (sel_w),
  .flag_ovf (flag_o[0]),
  .flag_c1  (flag_o[2]),
  .clr_ovf  (clr_w[0])
);

// File: tb/sim_lpwm_timer.sv
`timescale 1ns/1ps
module sim_lpwm_timer;
  localparam int W   = 16;
  localparam int MOD = 9;
  localparam int P   = MOD + 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic         gp_in;
  logic         pwm0_o;
  logic         pwm1_o;
  logic [2:0]   flag_o;
  logic         irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lpwm_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gp_in(gp_in), .pwm0_o(pwm0_o), .pwm1_o(pwm1_o),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns at the negedge of the first cycle of a period (count 0)
  task automatic sync_wrap();
    wr(3'd4, 16'h1);
    while (!flag_o[0]) @(negedge clk);
  endtask

  // samples n cycles from the current negedge, with up to two writes
  task automatic run_period(input int n,
                            input int ia, input logic [2:0] aa, input logic [W-1:0] da,
                            input int ib, input logic [2:0] ab, input logic [W-1:0] db,
                            output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b0;
      if (i == ia) begin wr_en = 1'b1; wr_addr = aa; wr_data = da; end
      if (i == ib) begin wr_en = 1'b1; wr_addr = ab; wr_data = db; end
      h0 += int'(pwm0_o);
      h1 += int'(pwm1_o);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pwm0 after reset", pwm0_o, 0);
    chk("R1 pwm1 after reset", pwm1_o, 0);
    chk("R1 flags after reset", flag_o, 0);
    chk("R1 irq after reset", irq_o, 0);
    wr(3'd0, 16'd3);
    repeat (20) @(negedge clk);
    chk("R1 counter idle without run", flag_o, 0);
  endtask

  task automatic t_free();
    int h0, h1, k;
    wr(3'd0, 16'(MOD));
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd7);
    wr(3'd3, 16'h10);
    sync_wrap();
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R3 ch0 width 3", h0, 3);
    chk("R3 ch1 width 7", h1, 7);
    sync_wrap();
    wr(3'd4, 16'h1);
    k = 1;
    while (!flag_o[0]) begin @(negedge clk); k++; end
    chk("R2 wrap period", k, P);
  endtask

  task automatic t_bounds();
    int h0, h1;
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd12);
    sync_wrap();
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R3 zero value gives 0%", h0, 0);
    chk("R3 value above modulus gives 100%", h1, P);
    wr(3'd1, 16'd1);
    sync_wrap();
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R3 width 1", h0, 1);
  endtask

  task automatic t_link();
    int h0, h1;
    wr(3'd1, 16'd4);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'h11);
    sync_wrap();
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R4 linked ch0 register width", h0, 4);
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R4 linked width held", h0, 4);
  endtask

  task automatic t_buffer();
    int h0, h1;
    run_period(P, 1, 3'd2, 16'd8, -1, 3'd0, 0, h0, h1);
    chk("R5 current period unchanged after ch1 write", h0, 4);
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R5 ch1 value at next period", h0, 8);
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R5 ch1 value kept", h0, 8);
  endtask

  task automatic t_last();
    int h0, h1;
    run_period(P, 1, 3'd1, 16'd2, 3, 3'd2, 16'd6, h0, h1);
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R6 later ch1 write wins", h0, 6);
    run_period(P, 1, 3'd2, 16'd5, 3, 3'd1, 16'd3, h0, h1);
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R6 later ch0 write wins", h0, 3);
  endtask

  task automatic t_linked_ch1();
    int h0, h1;
    wr(3'd3, 16'h19);
    gp_in = 1'b1; #1;
    chk("R7 ch1 pin follows gp_in high", pwm1_o, 1);
    @(negedge clk);
    gp_in = 1'b0; #1;
    chk("R7 ch1 pin follows gp_in low", pwm1_o, 0);
    @(negedge clk);
    sync_wrap();
    wr(3'd4, 16'h7);
    run_period(2 * P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R7 ch1 compare flag quiet", flag_o[2], 0);
    chk("R7 ch1 enable has no effect", irq_o, 0);
  endtask

  task automatic t_unlink();
    int h0, h1;
    wr(3'd3, 16'h10);
    sync_wrap();
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R9 ch0 register active after unlink", h0, 3);
    chk("R9 ch1 independent again", h1, 5);
  endtask

  task automatic t_flags();
    int h0, h1;
    wr(3'd3, 16'h14);
    sync_wrap();
    wr(3'd4, 16'h7);
    chk("R8 compare flag clear before match", flag_o[1], 0);
    chk("R8 irq low before match", irq_o, 0);
    repeat (2) @(negedge clk);
    chk("R8 compare flag set at match", flag_o[1], 1);
    chk("R8 irq with enabled flag", irq_o, 1);
    repeat (3) @(negedge clk);
    chk("R8 compare flag sticky", flag_o[1], 1);
    wr(3'd4, 16'h2);
    chk("R8 write-one clears flag", flag_o[1], 0);
    chk("R8 irq low after clear", irq_o, 0);
    wr(3'd3, 16'h10);
    run_period(P, -1, 3'd0, 0, -1, 3'd0, 0, h0, h1);
    chk("R8 flag sets with enable off", flag_o[1], 1);
    chk("R8 irq masked by enable", irq_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; gp_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_free();
    t_bounds();
    t_link();
    t_buffer();
    t_last();
    t_linked_ch1();
    t_unlink();
    t_flags();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule